// File: doc/BRIEF.md
# Three-Slot Wide-Word Issue Unit

This block sits at the front of a statically scheduled wide-word core. A single program counter addresses one bundle of three 32-bit operation slots. The bundle is captured into an issue register, and its three slots are decoded side by side. Each slot always goes to the same functional-unit class: slot 0 to an integer ALU, slot 1 to the load/store unit, and slot 2 to a unit that executes both branches and ALU operations.

The compiler is trusted to have built a legal bundle, so the unit does no dependence or resource checking between slots. The bundle issues as a whole in one cycle, or it waits in the issue register until every slot that has work to do sees its unit ready. Each slot names a predicate register. A slot whose predicate reads false is dropped silently, and so is a slot holding the no-op opcode.

A taken branch in slot 2 redirects the program counter on its issue cycle. The bundle fetched behind it is discarded, which costs exactly one empty cycle.

Top module: `vliw_issue_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `fetch_addr` is 0, `iss_fire` is 0 and every bit of `iss_valid` is 0; the bundle at address 0 is presented one cycle later.
- R2: `fetch_addr` is one above `iss_pc` whenever a bundle is presented and no redirect is pending; each accepted bundle moves the fetch address up by exactly one.
- R3: A slot is active when its opcode is nonzero and its predicate reads true. `iss_fire` is high only when every active slot has its `slot_ready` bit high. On fire, every active slot raises `iss_valid` in the same cycle. Otherwise no `iss_valid` bit is high and the same bundle stays presented.
- R4: Slot i occupies bundle bits [32*i+31:32*i]. Inside a slot, the fields are opcode [31:28], predicate index [27:25], rd [24:20], rs1 [19:15], rs2 [14:10] and imm [9:0]. All three slots' fields appear on the `iss_*` outputs at once.
- R5: Opcode 0 is a no-op. It never raises `iss_valid`, and its `slot_ready` bit has no effect on `iss_fire`.
- R6: A slot whose predicate reads false never raises `iss_valid`, drives no strobe, and its `slot_ready` bit has no effect on `iss_fire`.
- R7: `pred_idx[i]` carries slot i's predicate index, and `pred_val[i]` is taken as that register's value in the same cycle.
- R8: Slot 1 raises `ls_load` for opcode 8 and `ls_store` for opcode 9. Slot 2 raises `br_taken` for opcode 12. Each strobe is raised only together with that slot's `iss_valid`.
- R9: Slots that name the same destination register still issue together in one cycle.
- R10: Issue is strictly in order. The next bundle to fire after one at address A is at A+1, unless A held a taken branch.
- R11: When a branch is taken, the next cycle has no fire and `fetch_addr` equals the zero-extended imm field of slot 2. The bundle after the branch never issues, and the target bundle fires in the cycle after that. A branch whose predicate is false falls through with no empty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | PC_W | Bundle address for the instruction store |
| fetch_bundle | input | 96 | Bundle at `fetch_addr`, returned in the same cycle |
| pred_idx | output | 3x3 | Predicate register index read by each slot |
| pred_val | input | 3 | Predicate value for each slot |
| slot_ready | input | 3 | Ready from each slot's functional unit |
| iss_fire | output | 1 | The presented bundle issues this cycle |
| iss_pc | output | PC_W | Address of the presented bundle |
| iss_valid | output | 3 | Per-slot issue valid |
| iss_op | output | 3x4 | Per-slot opcode |
| iss_rd | output | 3x5 | Per-slot destination register |
| iss_rs1 | output | 3x5 | Per-slot first source register |
| iss_rs2 | output | 3x5 | Per-slot second source register |
| iss_imm | output | 3x10 | Per-slot immediate |
| ls_load | output | 1 | Load issued on slot 1 |
| ls_store | output | 1 | Store issued on slot 1 |
| br_taken | output | 1 | Taken branch issued on slot 2 |

## Verification
The properties assume a well-behaved instruction store: `fetch_bundle` is a pure function of `fetch_addr`, and `pred_val` depends only on `pred_idx` within a cycle. The bench meets both by computing each bundle arithmetically from its address and by reading predicates out of a small register array that it changes only at falling edges. The properties also assume the compiler's promise that a branch opcode appears only in slot 2. The bench's program keeps to that promise. The bench then sweeps all 64 combinations of the three ready bits and three predicate bits across bundles that mix loads, stores, ALU operations and no-op slots. A final run follows a fall-through branch and two taken branches.

// File: rtl/vliw_pkg.sv
package vliw_pkg;

    localparam int NSLOT    = 3;
    localparam int SLOT_W   = 32;
    localparam int OP_W     = 4;
    localparam int PIDX_W   = 3;
    localparam int REG_W    = 5;
    localparam int IMM_W    = SLOT_W - OP_W - PIDX_W - 3 * REG_W;
    localparam int BUNDLE_W = NSLOT * SLOT_W;

    localparam logic [OP_W-1:0] OP_NOP    = 4'd0;
    localparam logic [OP_W-1:0] OP_LOAD   = 4'd8;
    localparam logic [OP_W-1:0] OP_STORE  = 4'd9;
    localparam logic [OP_W-1:0] OP_BRANCH = 4'd12;

    typedef enum logic [1:0] {
        UNIT_ALU,
        UNIT_LDST,
        UNIT_BRALU
    } unit_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [PIDX_W-1:0] pidx;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rs1;
        logic [REG_W-1:0]  rs2;
        logic [IMM_W-1:0]  imm;
    } slot_t;

    typedef struct packed {
        logic load;
        logic store;
        logic branch;
    } strobe_t;

    function automatic slot_t slot_of(input logic [BUNDLE_W-1:0] b, input int idx);
        return slot_t'(b[idx*SLOT_W +: SLOT_W]);
    endfunction

    function automatic logic is_nop(input logic [OP_W-1:0] op);
        return op == OP_NOP;
    endfunction

    function automatic unit_e unit_of(input int idx);
        case (idx)
            0:       return UNIT_ALU;
            1:       return UNIT_LDST;
            default: return UNIT_BRALU;
        endcase
    endfunction

endpackage

// File: rtl/vliw_fetch_seq.sv
module vliw_fetch_seq
    import vliw_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BUNDLE_W-1:0] fetch_bundle,
    input  logic                fire,
    input  logic                redirect,
    input  logic [PC_W-1:0]     target,
    output logic [PC_W-1:0]     fetch_addr,
    output logic [BUNDLE_W-1:0] bundle,
    output logic                present,
    output logic [PC_W-1:0]     bundle_pc
);

    logic [PC_W-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            present   <= 1'b0;
            bundle    <= '0;
            bundle_pc <= '0;
        end else if (redirect) begin
            // the bundle fetched behind a taken branch is dropped
            pc      <= target;
            present <= 1'b0;
        end else if (fire || !present) begin
            bundle    <= fetch_bundle;
            bundle_pc <= pc;
            present   <= 1'b1;
            pc        <= pc + 1'b1;
        end
    end

    assign fetch_addr = pc;

endmodule

// File: rtl/vliw_slot_decode.sv
module vliw_slot_decode
    import vliw_pkg::*;
#(
    parameter unit_e UNIT = UNIT_ALU
) (
    input  logic [OP_W-1:0] op,
    input  logic            present,
    input  logic            pred_val,
    input  logic            ready,
    input  logic            fire,
    output logic            can_go,
    output logic            issue_v,
    output strobe_t         strobe
);

    logic active;

    assign active  = present && !is_nop(op) && pred_val;
    assign can_go  = !active || ready;
    assign issue_v = fire && active;

    if (UNIT == UNIT_LDST) begin : g_ldst
        assign strobe.load   = issue_v && (op == OP_LOAD);
        assign strobe.store  = issue_v && (op == OP_STORE);
        assign strobe.branch = 1'b0;
    end else if (UNIT == UNIT_BRALU) begin : g_bralu
        assign strobe.load   = 1'b0;
        assign strobe.store  = 1'b0;
        assign strobe.branch = issue_v && (op == OP_BRANCH);
    end else begin : g_alu
        assign strobe = '0;
    end

endmodule

// File: rtl/vliw_issue_ctrl.sv
module vliw_issue_ctrl
    import vliw_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic             present,
    input  logic [NSLOT-1:0] can_go,
    input  logic [IMM_W-1:0] branch_imm,
    output logic             fire,
    output logic [PC_W-1:0]  target
);

    // whole bundle or nothing: one stalled active slot blocks all three
    assign fire   = present && (&can_go);
    assign target = PC_W'(branch_imm);

endmodule

// File: rtl/vliw_issue_unit.sv
module vliw_issue_unit
    import vliw_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    output logic [PC_W-1:0]               fetch_addr,
    input  logic [BUNDLE_W-1:0]           fetch_bundle,
    output logic [NSLOT-1:0][PIDX_W-1:0]  pred_idx,
    input  logic [NSLOT-1:0]              pred_val,
    input  logic [NSLOT-1:0]              slot_ready,
    output logic                          iss_fire,
    output logic [PC_W-1:0]               iss_pc,
    output logic [NSLOT-1:0]              iss_valid,
    output logic [NSLOT-1:0][OP_W-1:0]    iss_op,
    output logic [NSLOT-1:0][REG_W-1:0]   iss_rd,
    output logic [NSLOT-1:0][REG_W-1:0]   iss_rs1,
    output logic [NSLOT-1:0][REG_W-1:0]   iss_rs2,
    output logic [NSLOT-1:0][IMM_W-1:0]   iss_imm,
    output logic                          ls_load,
    output logic                          ls_store,
    output logic                          br_taken
);

    logic                  present;
    logic [BUNDLE_W-1:0]   bundle;
    slot_t [NSLOT-1:0]     slots;
    logic [NSLOT-1:0]      can_go;
    strobe_t [NSLOT-1:0]   strobes;
    logic [PC_W-1:0]       target;

    vliw_fetch_seq #(.PC_W(PC_W)) i_fetch (
        .clk          (clk),
        .rst          (rst),
        .fetch_bundle (fetch_bundle),
        .fire         (iss_fire),
        .redirect     (br_taken),
        .target       (target),
        .fetch_addr   (fetch_addr),
        .bundle       (bundle),
        .present      (present),
        .bundle_pc    (iss_pc)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign slots[g]    = slot_of(bundle, g);
        assign pred_idx[g] = slots[g].pidx;
        assign iss_op[g]   = slots[g].op;
        assign iss_rd[g]   = slots[g].rd;
        assign iss_rs1[g]  = slots[g].rs1;
        assign iss_rs2[g]  = slots[g].rs2;
        assign iss_imm[g]  = slots[g].imm;

        vliw_slot_decode #(.UNIT(unit_of(g))) i_dec (
            .op       (slots[g].op),
            .present  (present),
            .pred_val (pred_val[g]),
            .ready    (slot_ready[g]),
            .fire     (iss_fire),
            .can_go   (can_go[g]),
            .issue_v  (iss_valid[g]),
            .strobe   (strobes[g])
        );
    end

    vliw_issue_ctrl #(.PC_W(PC_W)) i_ctrl (
        .present    (present),
        .can_go     (can_go),
        .branch_imm (slots[NSLOT-1].imm),
        .fire       (iss_fire),
        .target     (target)
    );

    always_comb begin
        ls_load  = 1'b0;
        ls_store = 1'b0;
        br_taken = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            ls_load  = ls_load  | strobes[i].load;
            ls_store = ls_store | strobes[i].store;
            br_taken = br_taken | strobes[i].branch;
        end
    end

endmodule

// File: rtl/vliw_issue_checker.sv
module vliw_issue_checker
    import vliw_pkg::*;
#(
    parameter int PC_W = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        present,
    input logic                        iss_fire,
    input logic                        br_taken,
    input logic                        ls_load,
    input logic                        ls_store,
    input logic [PC_W-1:0]             fetch_addr,
    input logic [PC_W-1:0]             iss_pc,
    input logic [NSLOT-1:0]            iss_valid,
    input logic [NSLOT-1:0]            slot_ready,
    input logic [NSLOT-1:0]            pred_val,
    input logic [NSLOT-1:0][OP_W-1:0]  iss_op,
    input logic [NSLOT-1:0][IMM_W-1:0] iss_imm
);

    logic            have_next;
    logic [PC_W-1:0] next_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_next <= 1'b0;
            next_pc   <= '0;
        end else if (iss_fire) begin
            have_next <= 1'b1;
            next_pc   <= br_taken ? PC_W'(iss_imm[NSLOT-1]) : iss_pc + 1'b1;
        end
    end

    // R3: no slot valid outside a firing cycle
    a_r3_valid_needs_fire: assert property (@(posedge clk) disable iff (rst)
        (iss_valid != '0) |-> iss_fire);

    // R3: a valid slot always had its unit ready
    a_r3_valid_needs_ready: assert property (@(posedge clk) disable iff (rst)
        iss_fire |-> ((iss_valid & ~slot_ready) == '0));

    // R3: a held bundle keeps its address and the fetch address
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (present && !iss_fire) |=> ($stable(iss_pc) && $stable(fetch_addr)));

    // R2: one bundle of address advance per accepted bundle
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (iss_fire && !br_taken) |=> (fetch_addr == $past(fetch_addr) + 1'b1));

    // R10: fired bundles form an in-order chain
    a_r10_in_order: assert property (@(posedge clk) disable iff (rst)
        (iss_fire && have_next) |-> (iss_pc == next_pc));

    // R11: taken branch redirects and leaves one empty cycle
    a_r11_redirect: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> (!iss_fire && fetch_addr == PC_W'($past(iss_imm[NSLOT-1]))));

    // R8: strobes only with the owning slot's valid
    a_r8_load_strobe: assert property (@(posedge clk) disable iff (rst)
        ls_load |-> (iss_valid[1] && iss_op[1] == OP_LOAD));
    a_r8_store_strobe: assert property (@(posedge clk) disable iff (rst)
        ls_store |-> (iss_valid[1] && iss_op[1] == OP_STORE));
    a_r8_branch_strobe: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (iss_valid[NSLOT-1] && iss_op[NSLOT-1] == OP_BRANCH));

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot_chk
        // R5: no-op slots stay silent
        a_r5_nop_silent: assert property (@(posedge clk) disable iff (rst)
            (iss_op[g] == OP_NOP) |-> !iss_valid[g]);
        // R6: false predicate blocks the slot
        a_r6_pred_gate: assert property (@(posedge clk) disable iff (rst)
            iss_valid[g] |-> pred_val[g]);
    end

endmodule

bind vliw_issue_unit vliw_issue_checker #(.PC_W(PC_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .present    (present),
    .iss_fire   (iss_fire),
    .br_taken   (br_taken),
    .ls_load    (ls_load),
    .ls_store   (ls_store),
    .fetch_addr (fetch_addr),
    .iss_pc     (iss_pc),
    .iss_valid  (iss_valid),
    .slot_ready (slot_ready),
    .pred_val   (pred_val),
    .iss_op     (iss_op),
    .iss_imm    (iss_imm)
);

// File: tb/test_vliw_issue_unit.sv
module test_vliw_issue_unit;
    import vliw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 16;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic [PC_W-1:0]              fetch_addr;
    logic [BUNDLE_W-1:0]          fetch_bundle;
    logic [NSLOT-1:0][PIDX_W-1:0] pred_idx;
    logic [NSLOT-1:0]             pred_val;
    logic [NSLOT-1:0]             slot_ready = '0;
    logic                         iss_fire;
    logic [PC_W-1:0]              iss_pc;
    logic [NSLOT-1:0]             iss_valid;
    logic [NSLOT-1:0][OP_W-1:0]   iss_op;
    logic [NSLOT-1:0][REG_W-1:0]  iss_rd, iss_rs1, iss_rs2;
    logic [NSLOT-1:0][IMM_W-1:0]  iss_imm;
    logic                         ls_load, ls_store, br_taken;
    logic [7:0]                   pred_file = 8'hFF;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vliw_issue_unit #(.PC_W(PC_W)) i_vliw_issue_unit (
        .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_bundle(fetch_bundle),
        .pred_idx(pred_idx), .pred_val(pred_val), .slot_ready(slot_ready),
        .iss_fire(iss_fire), .iss_pc(iss_pc), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2), .iss_imm(iss_imm),
        .ls_load(ls_load), .ls_store(ls_store), .br_taken(br_taken)
    );

    function automatic logic [31:0] mk(input int op, input int p, input int rd,
                                       input int rs1, input int rs2, input int imm);
        return {4'(op), 3'(p), 5'(rd), 5'(rs1), 5'(rs2), 10'(imm)};
    endfunction

    // program: bundle contents are a function of the address
    function automatic logic [BUNDLE_W-1:0] prog(input int a);
        logic [31:0] s0, s1, s2;
        s0 = (a % 4 == 3) ? 32'd0 : mk(1 + a % 7, 1, a, a + 1, a + 2, a * 3);
        s1 = mk((a % 2 == 1) ? 9 : 8, 2, a, a + 3, a + 4, a + 5);
        s2 = (a % 4 == 1) ? 32'd0 : mk(1 + a % 5, 3, a, a + 6, a + 7, a);
        if (a == 70)  s2 = mk(12, 0, 0, 0, 0, 100);
        if (a == 100) s2 = mk(12, 5, 0, 0, 0, 110);
        if (a == 101) s2 = mk(12, 4, 0, 0, 0, 120);
        return {s2, s1, s0};
    endfunction

    always_comb fetch_bundle = prog(int'(fetch_addr));
    always_comb for (int i = 0; i < NSLOT; i++) pred_val[i] = pred_file[pred_idx[i]];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int exp_pc;
        int gap;
        bit last_taken;
        logic [BUNDLE_W-1:0] b;
        logic [31:0] s;
        logic [NSLOT-1:0] act, exp_valid;
        bit exp_fire;

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check(fetch_addr == 0, "R1 addr in reset", int'(fetch_addr), 0);
        check(iss_fire == 0 && iss_valid == 0, "R1 valid in reset", int'(iss_valid), 0);
        rst = 1'b0;
        #1;
        check(fetch_addr == 0 && iss_fire == 0, "R1 first cycle", int'(fetch_addr), 0);
        check(iss_valid == 0, "R1 first cycle valid", int'(iss_valid), 0);
        @(negedge clk);

        // sweep of ready x predicate over consecutive bundles
        exp_pc = 0;
        for (int c = 0; c < 64; c++) begin
            slot_ready   = 3'(c);
            pred_file    = {4'hF, 3'(c >> 3), 1'b1};
            #1;
            check(int'(iss_pc) == exp_pc, "R10 bundle order", int'(iss_pc), exp_pc);
            check(int'(fetch_addr) == exp_pc + 1, "R2 fetch advance", int'(fetch_addr), exp_pc + 1);
            b = prog(exp_pc);
            for (int i = 0; i < NSLOT; i++) begin
                s = b[32*i +: 32];
                act[i] = (s[31:28] != 0) && pred_file[s[27:25]];
                check(iss_op[i] == s[31:28] && iss_rd[i] == s[24:20] && iss_rs1[i] == s[19:15]
                      && iss_rs2[i] == s[14:10] && iss_imm[i] == s[9:0],
                      "R4 slot fields", int'(iss_op[i]), int'(s[31:28]));
                check(pred_idx[i] == s[27:25], "R7 predicate index", int'(pred_idx[i]), int'(s[27:25]));
            end
            exp_fire  = ((act & ~slot_ready) == 0);
            exp_valid = exp_fire ? act : 3'b000;
            check(iss_fire == exp_fire, "R3 fire all-or-none", int'(iss_fire), int'(exp_fire));
            check(iss_valid == exp_valid, "R3/R5/R6 slot valids", int'(iss_valid), int'(exp_valid));
            if (act == 3'b111 && exp_fire)
                check(iss_valid == 3'b111, "R9 same rd issue together", int'(iss_valid), 7);
            check(ls_load == (exp_valid[1] && b[63:60] == 4'd8), "R8 load strobe",
                  int'(ls_load), int'(exp_valid[1] && b[63:60] == 4'd8));
            check(ls_store == (exp_valid[1] && b[63:60] == 4'd9), "R8 store strobe",
                  int'(ls_store), int'(exp_valid[1] && b[63:60] == 4'd9));
            check(br_taken == 0, "R6 no branch in sweep", int'(br_taken), 0);
            if (exp_fire) exp_pc++;
            @(negedge clk);
        end

        // branch run: fall-through branch at 100, taken branches at 70 and 101
        slot_ready = 3'b111;
        pred_file  = 8'b1101_1111;
        gap        = 0;
        last_taken = 0;
        for (int k = 0; k < 200; k++) begin
            #1;
            if (iss_fire) begin
                check(int'(iss_pc) == exp_pc, "R10/R11 issue sequence", int'(iss_pc), exp_pc);
                check(gap == (last_taken ? 1 : 0), "R11 bubble count", gap, last_taken ? 1 : 0);
                b = prog(exp_pc);
                check(br_taken == (b[95:92] == 4'd12 && pred_file[b[91:89]]), "R11 taken flag",
                      int'(br_taken), int'(b[95:92] == 4'd12 && pred_file[b[91:89]]));
                last_taken = br_taken;
                exp_pc = br_taken ? int'(b[73:64]) : exp_pc + 1;
                gap = 0;
                if (int'(iss_pc) == 122) break;
            end else begin
                gap++;
                if (last_taken)
                    check(int'(fetch_addr) == exp_pc, "R11 redirect address", int'(fetch_addr), exp_pc);
            end
            @(negedge clk);
        end
        check(exp_pc == 123, "R11 reached end", exp_pc, 123);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule